// File: doc/BRIEF.md
# Byte Subtract Execution Unit

This unit executes two byte-wide subtract instructions for a small accumulator machine. In both, the working register is the subtrahend. The immediate form subtracts it from an 8-bit constant carried in the instruction word. The memory form subtracts it from a byte read out of data memory. The memory form can then put the difference back into that byte or into the working register.

A free-running phase sequencer splits each instruction cycle into four phases:

1. Latch and decode the instruction word.
2. Issue the data-memory read.
3. Capture the operand.
4. Commit the result and the status flags.

A memory-form address comes from one of two places. The fixed access window folds the low and high halves of the 8-bit field onto the bottom and top of data memory. Otherwise a bank-select value supplies the upper address bits. A word that encodes neither instruction changes nothing.

Top module: `bsub_exec_unit`

## Requirements
- R1: While `rst` is high and after it falls, `w_reg` and `status` are 0, `phase` is 0, and neither memory enable is asserted.
- R2: `phase` steps 0,1,2,3 and then wraps, one step per clock. `w_reg` and `status` change only on the clock edge that ends phase 3.
- R3: A word with bits [15:8] = 8'h08 is the immediate form: `w_reg` becomes bits[7:0] minus `w_reg`, modulo 256.
- R4: A word with bits [15:10] = 6'b010111 is the memory form. Its operand is the data-memory byte. `mem_rd_en` is high only in phase 1, and only for this form.
- R5: For the memory form, bit 9 = 0 puts the difference in `w_reg`. Bit 9 = 1 pulses `mem_wr_en` once in phase 3 with the difference on `mem_wdata`, and `w_reg` is left unchanged.
- R6: Memory-form bit 8 = 0 selects the access window. Field values below ACCESS_SPLIT address 0 upward. Values at or above ACCESS_SPLIT address the top of memory (upper bits all ones). `bank_sel` is ignored.
- R7: Memory-form bit 8 = 1 forms the address as {`bank_sel`, bits[7:0]}.
- R8: `status[0]` (carry) is 1 when minuend ≥ subtrahend as unsigned values, so it is an inverted borrow.
- R9: `status[1]` (digit carry) is 1 when the low nibble of the minuend is ≥ the low nibble of the subtrahend.
- R10: `status[2]` (zero) is 1 for a zero difference. `status[4]` (negative) equals bit 7 of the difference.
- R11: `status[3]` (overflow) is 1 when the two's-complement difference lies outside −128..127.
- R12: Any other instruction word leaves `w_reg`, `status` and memory unchanged and asserts no memory enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| bank_sel | input | ADDR_W-8 | Bank-select value, sampled with the instruction |
| phase | output | 2 | Current phase of the instruction cycle |
| mem_addr | output | ADDR_W | Data-memory byte address |
| mem_rd_en | output | 1 | Read request; data is expected on the next cycle |
| mem_rdata | input | 8 | Read data from synchronous memory |
| mem_wr_en | output | 1 | Write strobe, phase 3 |
| mem_wdata | output | 8 | Write data |
| w_reg | output | 8 | Working register |
| status | output | 5 | {negative, overflow, zero, digit carry, carry} |

## Verification
The bench uses the default ADDR_W of 12 and ACCESS_SPLIT of 8'h80. With these values a 4096-byte bench memory reaches both ends of the access window, a mid-range bank, and the last byte at FFFh. A reference model in the bench follows the working-register value through a chain of immediate and memory subtracts. Through that chain it reaches zero, negative, overflow and nibble-borrow results, and write-back into the top of memory.

// File: rtl/bsub_pkg.sv
package bsub_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 16;
    localparam int FLAG_W  = 5;

    localparam logic [7:0] IMM_OPCODE = 8'h08;
    localparam logic [5:0] MEM_OPCODE = 6'b010111;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_PROC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_IMM  = 2'd1,
        OPK_MEM  = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic                to_mem;
        logic                banked;
        logic [DATA_W-1:0]   fld;
    } dec_t;

    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] diff;
        flags_t            fl;
    } alu_out_t;

    function automatic dec_t decode_word(input logic [INSTR_W-1:0] word);
        dec_t d;
        d        = '0;
        d.kind   = OPK_NONE;
        d.fld    = word[7:0];
        if (word[15:8] == IMM_OPCODE) begin
            d.kind = OPK_IMM;
        end else if (word[15:10] == MEM_OPCODE) begin
            d.kind   = OPK_MEM;
            d.to_mem = word[9];
            d.banked = word[8];
        end
        return d;
    endfunction

endpackage

// File: rtl/bsub_phase_seq.sv
module bsub_phase_seq
    import bsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_DECODE;
        end else begin
            unique case (ph)
                PH_DECODE: ph <= PH_READ;
                PH_READ:   ph <= PH_PROC;
                PH_PROC:   ph <= PH_WRITE;
                default:   ph <= PH_DECODE;
            endcase
        end
    end
endmodule

// File: rtl/bsub_addr_gen.sv
module bsub_addr_gen #(
    parameter int          ADDR_W       = 12,
    parameter logic [7:0]  ACCESS_SPLIT = 8'h80,
    localparam int         BANK_W       = ADDR_W - 8
) (
    input  logic [7:0]        fld,
    input  logic              banked,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [BANK_W-1:0] TOP_BANK = {BANK_W{1'b1}};
    localparam logic [BANK_W-1:0] LOW_BANK = '0;

    logic [BANK_W-1:0] upper;

    always_comb begin
        if (banked) begin
            upper = bank;
        end else if (fld >= ACCESS_SPLIT) begin
            upper = TOP_BANK;
        end else begin
            upper = LOW_BANK;
        end
        addr = {upper, fld};
    end
endmodule

// File: rtl/bsub_alu.sv
module bsub_alu
    import bsub_pkg::*;
(
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtra,
    output alu_out_t          res
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W:0]  wide;
    logic [NIB_W:0]   nib;
    logic [DATA_W-1:0] d;

    always_comb begin
        wide = {1'b0, minuend} - {1'b0, subtra};
        nib  = {1'b0, minuend[NIB_W-1:0]} - {1'b0, subtra[NIB_W-1:0]};
        d    = wide[DATA_W-1:0];

        res.diff  = d;
        res.fl.c  = ~wide[DATA_W];
        res.fl.dc = ~nib[NIB_W];
        res.fl.z  = (d == '0);
        res.fl.n  = d[DATA_W-1];
        res.fl.ov = (minuend[DATA_W-1] ^ subtra[DATA_W-1]) &
                    (d[DATA_W-1] ^ minuend[DATA_W-1]);
    end
endmodule

// File: rtl/bsub_exec_unit.sv
module bsub_exec_unit
    import bsub_pkg::*;
#(
    parameter int         ADDR_W       = 12,
    parameter logic [7:0] ACCESS_SPLIT = 8'h80,
    localparam int        BANK_W       = ADDR_W - 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         instr,
    input  logic [BANK_W-1:0]   bank_sel,
    output logic [1:0]          phase,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd_en,
    input  logic [7:0]          mem_rdata,
    output logic                mem_wr_en,
    output logic [7:0]          mem_wdata,
    output logic [7:0]          w_reg,
    output logic [4:0]          status
);
    phase_e            ph;
    dec_t              ir_q;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] w_q;
    flags_t            st_q;
    alu_out_t          alu_res;

    bsub_phase_seq u_seq (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    bsub_addr_gen #(
        .ADDR_W       (ADDR_W),
        .ACCESS_SPLIT (ACCESS_SPLIT)
    ) u_addr (
        .fld    (ir_q.fld),
        .banked (ir_q.banked),
        .bank   (bank_q),
        .addr   (mem_addr)
    );

    bsub_alu u_alu (
        .minuend (opnd_q),
        .subtra  (w_q),
        .res     (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q   <= '0;
            bank_q <= '0;
            opnd_q <= '0;
            w_q    <= '0;
            st_q   <= '0;
        end else begin
            unique case (ph)
                PH_DECODE: begin
                    ir_q   <= decode_word(instr);
                    bank_q <= bank_sel;
                end
                PH_READ: begin
                end
                PH_PROC: begin
                    opnd_q <= (ir_q.kind == OPK_MEM) ? mem_rdata : ir_q.fld;
                end
                default: begin
                    if (ir_q.kind != OPK_NONE) begin
                        st_q <= alu_res.fl;
                        if (ir_q.kind == OPK_IMM || !ir_q.to_mem) begin
                            w_q <= alu_res.diff;
                        end
                    end
                end
            endcase
        end
    end

    assign phase     = ph;
    assign mem_rd_en = (ph == PH_READ) && (ir_q.kind == OPK_MEM);
    assign mem_wr_en = (ph == PH_WRITE) && (ir_q.kind == OPK_MEM) && ir_q.to_mem;
    assign mem_wdata = alu_res.diff;
    assign w_reg     = w_q;
    assign status    = st_q;
endmodule

// File: rtl/bsub_exec_checker.sv
module bsub_exec_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] w_reg,
    input logic [4:0] status
);
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase == $past(phase) + 2'd1));

    p_commit_q4_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> ($stable(w_reg) && $stable(status)));

    p_read_q2_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (phase == 2'd1));

    p_write_q4_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (phase == 2'd3));

    p_write_keeps_w_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> $stable(w_reg));

    p_zero_flags_r10: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> (status[0] && status[1] && !status[4] && !status[3]));

    p_one_enable_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

bind bsub_exec_unit bsub_exec_checker i_bsub_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .w_reg     (w_reg),
    .status    (status)
);

// File: tb/test_bsub_exec_unit.sv
module test_bsub_exec_unit;
    localparam int ADDR_W = 12;
    localparam int BANK_W = ADDR_W - 8;
    localparam int MEM_N  = 1 << ADDR_W;
    localparam int NV     = 15;

    // {bank_sel, instr}
    localparam logic [19:0] VEC [NV] = '{
        20'h0_0805, 20'h0_0805, 20'h0_0803, 20'h0_0802, 20'h0_087F,
        20'h0_5C10, 20'h0_5E85, 20'h3_5D22, 20'h3_5F22, 20'h9_5E40,
        20'h0_0900, 20'hF_5FFF, 20'h0_5800, 20'h0_0810, 20'h0_FFFF
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [15:0]       instr;
    logic [BANK_W-1:0] bank_sel;
    logic [1:0]        phase;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd_en;
    logic [7:0]        mem_rdata;
    logic              mem_wr_en;
    logic [7:0]        mem_wdata;
    logic [7:0]        w_reg;
    logic [4:0]        status;

    logic [7:0] mem [MEM_N];
    int         wr_count = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] exp_w = 8'h00;
    logic [4:0] exp_st = 5'h00;

    always #5 clk = ~clk;

    bsub_exec_unit i_bsub_exec_unit (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .bank_sel  (bank_sel),
        .phase     (phase),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_rdata (mem_rdata),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .w_reg     (w_reg),
        .status    (status)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= 8'((i * 37 + 5) & 255);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_wr_en) begin
                mem[mem_addr] <= mem_wdata;
                wr_count      <= wr_count + 1;
            end
            if (mem_rd_en) mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge with phase == 0.
    task automatic run_op(input logic [15:0] ins, input logic [BANK_W-1:0] bk);
        bit          is_imm, is_mem, d, a;
        logic [7:0]  f, m, res;
        logic [ADDR_W-1:0] addr;
        int          sm, sw, sd, wc0;
        logic [7:0]  w0;
        logic [4:0]  st0;
        logic        c, dc, z, n, ov;

        is_imm = (ins[15:8] == 8'h08);
        is_mem = (ins[15:10] == 6'b010111);
        d = ins[9]; a = ins[8]; f = ins[7:0];
        if (a) addr = {bk, f};
        else if (f >= 8'h80) addr = {{BANK_W{1'b1}}, f};
        else addr = {{BANK_W{1'b0}}, f};
        m   = is_imm ? f : mem[addr];
        res = 8'((int'(m) - int'(exp_w)) & 255);
        c   = (m >= exp_w);
        dc  = ((m & 8'h0F) >= (exp_w & 8'h0F));
        z   = (res == 8'h00);
        n   = res[7];
        sm  = (m > 127) ? int'(m) - 256 : int'(m);
        sw  = (exp_w > 127) ? int'(exp_w) - 256 : int'(exp_w);
        sd  = sm - sw;
        ov  = (sd > 127) || (sd < -128);
        w0  = exp_w; st0 = exp_st; wc0 = wr_count;

        instr = ins; bank_sel = bk;
        @(negedge clk);
        chk("R2 phase1", int'(phase), 1);
        chk("R4 rd_en", int'(mem_rd_en), int'(is_mem));
        if (is_mem) chk(a ? "R7 addr" : "R6 addr", int'(mem_addr), int'(addr));
        chk("R2 w hold", int'(w_reg), int'(w0));
        @(negedge clk);
        chk("R2 phase2", int'(phase), 2);
        @(negedge clk);
        chk("R2 phase3", int'(phase), 3);
        chk("R2 st hold", int'(status), int'(st0));
        chk("R5 wr_en", int'(mem_wr_en), int'(is_mem && d));
        @(negedge clk);

        if (is_imm || is_mem) begin
            exp_st = {n, ov, z, dc, c};
            if (is_imm || !d) exp_w = res;
            chk(is_imm ? "R3 w" : "R5 w", int'(w_reg), int'(exp_w));
            chk("R8 carry", int'(status[0]), int'(c));
            chk("R9 dcarry", int'(status[1]), int'(dc));
            chk("R10 zero", int'(status[2]), int'(z));
            chk("R10 neg", int'(status[4]), int'(n));
            chk("R11 ovf", int'(status[3]), int'(ov));
            if (is_mem && d) begin
                chk("R5 mem byte", int'(mem[addr]), int'(res));
                chk("R5 writes", wr_count, wc0 + 1);
            end else begin
                chk("R5 no write", wr_count, wc0);
            end
        end else begin
            chk("R12 w", int'(w_reg), int'(w0));
            chk("R12 status", int'(status), int'(st0));
            chk("R12 writes", wr_count, wc0);
        end
        instr = 16'hFFFF;
    endtask

    task automatic set_w(input logic [7:0] target);
        run_op({8'h08, 8'(target + exp_w)}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; instr = 16'hFFFF; bank_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 w", int'(w_reg), 0);
        chk("R1 status", int'(status), 0);
        chk("R1 phase", int'(phase), 0);
        chk("R1 rd_en", int'(mem_rd_en), 0);
        chk("R1 wr_en", int'(mem_wr_en), 0);

        // R3 fixed examples from a cleared register
        run_op(16'h0802, '0);
        chk("R3 load", int'(w_reg), 2);
        run_op(16'h0802, '0);
        chk("R10 zero ex", int'(status), 5'b00111);
        run_op(16'h0801, '0);
        chk("R8 pos ex", int'(status), 5'b00011);
        run_op(16'h0800, '0);
        chk("R8 neg ex", int'(w_reg), 8'hFF);
        chk("R8 neg st", int'(status), 5'b10000);

        for (int i = 0; i < NV; i++) run_op(VEC[i][15:0], VEC[i][19:16]);

        // R11 overflow corner: 7F - FF
        set_w(8'hFF);
        run_op(16'h087F, '0);
        chk("R11 ovf ex", int'(status[3]), 1);
        chk("R11 w ex", int'(w_reg), 8'h80);
        // R9 nibble borrow corner: 10 - 0F
        set_w(8'h0F);
        run_op(16'h0810, '0);
        chk("R9 dc ex", int'(status), 5'b00001);
        // R6 access boundary 7F / 80
        run_op(16'h5C7F, 4'h5);
        run_op(16'h5C80, 4'h5);

        // R1 reset in the middle of an instruction
        instr = 16'h0833;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_w = 8'h00; exp_st = 5'h00;
        chk("R1 mid w", int'(w_reg), 0);
        chk("R1 mid status", int'(status), 0);
        chk("R1 mid phase", int'(phase), 0);
        run_op(16'h0844, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule